// File: doc/BRIEF.md
# AES-128 Round Key Expander

This block turns a 128-bit cipher key into the full set of eleven 128-bit round keys and holds them in an internal register bank. A single-cycle `load` pulse captures the key as round key 0. The block then produces one further round key on each following clock until all ten derived keys are stored, and raises `ready`. The word substitution, the byte rotation and the round constants are computed inside the block.

Once `ready` is high, an encryption or decryption datapath reads any round key by index through a combinational read port. Keys can be fetched in forward order for encryption, in reverse order for decryption, or in any other order. No regeneration takes place. A new `load` at any time, even in the middle of an expansion, drops `ready` and restarts from the new key.

Both the key input and the read port are plain control and status pins. There is no valid/ready stream, so there is no back-pressure. The key is sampled only in the cycle where `load` is high, and a read is answered in the same cycle it is presented.

Top module: `keysched128`

## Requirements
- R1: After reset, `ready` is 0 and every index 0 to 15 reads as all zeros; `ready` never rises without a preceding `load`.
- R2: The clock edge that samples `load` high stores `key_in` as round key 0 (index 0), and index 0 returns that value from the next cycle.
- R3: `ready` rises exactly 10 clock edges after the edge that sampled `load`, with round keys 1 to 10 written one per edge in between.
- R4: Word i of the schedule (word 0 being bits 127:96 of round key 0) is w[i-4] XOR t. For i a multiple of 4, t is the S-box applied to each byte of w[i-1] after a one-byte left rotation, XOR a round constant placed in the top byte. Otherwise t is w[i-1].
- R5: The round constants for round keys 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 (hex). For key 2b7e151628aed2a6abf7158809cf4f3c, round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R6: A `load` while an expansion runs, or while `ready` is high, forces `ready` to 0 on the next edge and restarts expansion from the new key, with the R3 timing counted from the new `load`.
- R7: Once high, `ready` and all stored round keys stay unchanged until the next `load`.
- R8: The read port is random access. `rd_key` is the round key selected by `rd_idx` (0 to 10) in the same cycle, and any index from 11 to 15 returns all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle pulse that captures `key_in` and starts expansion |
| key_in | input | 128 | Cipher key, bits 127:96 form word 0 |
| ready | output | 1 | All eleven round keys are valid |
| rd_idx | input | 4 | Round key index to read |
| rd_key | output | 128 | Selected round key, combinational |

## Verification
The schedule is run with four keys, each of which tells apart a different kind of fault. The published test key pins down the exact byte order and the round-constant sequence. An all-zero key isolates the S-box constant and the round constants, because the XOR chain contributes nothing. An all-ones key exposes stuck or inverted data bits. An irregular key catches rotation-direction and word-chaining mistakes. Reads are issued in both forward and reverse order, and out-of-range indices are read as well. A reload during a running expansion and a reload after completion show that the restart timing and the bank contents follow the newest key.

// File: rtl/ks_pkg.sv
package ks_pkg;

  typedef enum logic [1:0] {KS_IDLE, KS_RUN, KS_DONE} ks_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = gf_xtime(aa);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fn(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  // constant for round key r (1-based): doubling in GF(2^8) from 01
  function automatic logic [7:0] rcon_fn(input logic [3:0] r);
    logic [7:0] v;
    v = 8'h01;
    for (int k = 2; k <= 15; k++) begin
      if (k <= int'(r)) v = gf_xtime(v);
    end
    return v;
  endfunction

endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
  import ks_pkg::*;
(
  input  logic [7:0] a,
  output logic [7:0] y
);
  always_comb y = sbox_fn(a);
endmodule

// File: rtl/ks_step.sv
module ks_step #(
  parameter int KEY_W = 128
) (
  input  logic [KEY_W-1:0] prev,
  input  logic [7:0]       rcon,
  output logic [KEY_W-1:0] nxt
);
  localparam int WORD_W = 32;
  localparam int NWORDS = KEY_W / WORD_W;
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] last_w;
  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] sub_w;
  logic [WORD_W-1:0] temp_w;
  logic [WORD_W-1:0] nw [NWORDS];

  assign last_w = prev[WORD_W-1:0];
  assign rot_w  = {last_w[WORD_W-9:0], last_w[WORD_W-1 -: 8]};

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    ks_sbox u_sbox (.a(rot_w[b*8 +: 8]), .y(sub_w[b*8 +: 8]));
  end

  assign temp_w = sub_w ^ {rcon, {(WORD_W-8){1'b0}}};

  for (genvar w = 0; w < NWORDS; w++) begin : g_chain
    if (w == 0) begin : g_first
      assign nw[w] = prev[KEY_W-1 -: WORD_W] ^ temp_w;
    end else begin : g_rest
      assign nw[w] = prev[KEY_W-1-w*WORD_W -: WORD_W] ^ nw[w-1];
    end
    assign nxt[KEY_W-1-w*WORD_W -: WORD_W] = nw[w];
  end
endmodule

// File: rtl/ks_bank.sv
module ks_bank #(
  parameter int NKEYS = 11,
  parameter int KEY_W = 128,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [KEY_W-1:0] wdata,
  input  logic [IW-1:0]    raddr,
  output logic [KEY_W-1:0] rdata
);
  localparam logic [IW-1:0] LAST = IW'(NKEYS - 1);

  logic [KEY_W-1:0] mem [NKEYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NKEYS; i++) mem[i] <= '0;
    end else if (we && waddr <= LAST) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (raddr == IW'(i)) rdata = mem[i];
    end
  end

  logic unused_last;
  assign unused_last = ^LAST;
endmodule

// File: rtl/keysched128.sv
module keysched128
  import ks_pkg::*;
#(
  parameter int KEY_W   = 128,
  parameter int NROUNDS = 10,
  parameter int NKEYS   = NROUNDS + 1,
  parameter int IW      = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key_in,
  output logic             ready,
  input  logic [IW-1:0]    rd_idx,
  output logic [KEY_W-1:0] rd_key
);
  localparam logic [IW-1:0] LAST_RND = IW'(NROUNDS);

  ks_state_e        state_q;
  logic [IW-1:0]    rnd_q;
  logic [KEY_W-1:0] cur_q;
  logic [KEY_W-1:0] next_key;
  logic [7:0]       rcon;
  logic             bank_we;
  logic [IW-1:0]    bank_waddr;
  logic [KEY_W-1:0] bank_wdata;

  always_comb rcon = rcon_fn(4'(rnd_q));

  ks_step #(.KEY_W(KEY_W)) u_step (
    .prev (cur_q),
    .rcon (rcon),
    .nxt  (next_key)
  );

  always_comb begin
    bank_we    = load || (state_q == KS_RUN);
    bank_waddr = load ? '0 : rnd_q;
    bank_wdata = load ? key_in : next_key;
  end

  ks_bank #(.NKEYS(NKEYS), .KEY_W(KEY_W), .IW(IW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bank_we),
    .waddr (bank_waddr),
    .wdata (bank_wdata),
    .raddr (rd_idx),
    .rdata (rd_key)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
      rnd_q   <= '0;
      cur_q   <= '0;
    end else if (load) begin
      state_q <= KS_RUN;
      rnd_q   <= IW'(1);
      cur_q   <= key_in;
    end else if (state_q == KS_RUN) begin
      cur_q <= next_key;
      if (rnd_q == LAST_RND) begin
        state_q <= KS_DONE;
      end else begin
        rnd_q <= rnd_q + IW'(1);
      end
    end
  end

  assign ready = (state_q == KS_DONE);
endmodule

// File: rtl/ks_chk.sv
module ks_chk #(
  parameter int KEY_W   = 128,
  parameter int NROUNDS = 10,
  parameter int IW      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [KEY_W-1:0] key_in,
  input logic             ready,
  input logic [IW-1:0]    rd_idx,
  input logic [KEY_W-1:0] rd_key
);
  localparam logic [5:0] RISE_AT = 6'(NROUNDS + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NROUNDS);

  // edges since the last load, saturating
  logic [5:0] since_load;
  always_ff @(posedge clk) begin
    if (!rst_n)                                       since_load <= '0;
    else if (load)                                    since_load <= 6'd1;
    else if (since_load != '0 && since_load != 6'h3f) since_load <= since_load + 6'd1;
  end

  a_r1_no_ready_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> since_load != '0);

  a_r2_key0_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && rd_idx == '0) |-> rd_key == $past(key_in));

  a_r3_ready_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> since_load == RISE_AT);

  a_r6_load_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);

  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load) |=> ready);

  a_r8_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > LAST_IDX) |-> rd_key == '0);
endmodule

bind keysched128 ks_chk #(.KEY_W(KEY_W), .NROUNDS(NROUNDS), .IW(IW)) u_ks_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load   (load),
  .key_in (key_in),
  .ready  (ready),
  .rd_idx (rd_idx),
  .rd_key (rd_key)
);

// File: tb/tb_keysched128.sv
`timescale 1ns/1ps
module tb_keysched128;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [127:0] key_in = '0;
  logic         ready;
  logic [3:0]   rd_idx = '0;
  logic [127:0] rd_key;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_en   = 1'b0;

  typedef struct {
    logic [3:0]   idx;
    logic [127:0] exp;
    int           req;
  } item_t;
  item_t sbq[$];

  logic [7:0]   sb [256];
  logic [127:0] exp_rk [11];

  always #4 clk = ~clk;

  keysched128 dut (
    .clk(clk), .rst_n(rst_n), .load(load), .key_in(key_in),
    .ready(ready), .rd_idx(rd_idx), .rd_key(rd_key)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box built by walking the field with generator 3 and its inverse
  task automatic build_sbox();
    logic [7:0] p = 8'h01;
    logic [7:0] q = 8'h01;
    logic [7:0] x;
    do begin
      p = p ^ xt(p);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  // reference schedule, R4 and R5
  task automatic ref_expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) exp_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic check(input int req, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d got %h exp %h", req, got, exp);
    end
  endtask

  task automatic push(input logic [3:0] idx, input logic [127:0] exp, input int req);
    item_t it;
    it.idx = idx; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic push_all(input bit reverse, input int req);
    for (int k = 0; k < 11; k++) begin
      int r = reverse ? 10 - k : k;
      push(4'(r), exp_rk[r], req);
    end
  endtask

  task automatic drain();
    mon_en = 1'b1;
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  // monitor: pops expected items and compares the read port
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (mon_en && sbq.size() > 0) begin
        it = sbq.pop_front();
        rd_idx = it.idx;
        #1;
        n_checks++;
        if (rd_key !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d idx %0d got %h exp %h", it.req, it.idx, rd_key, it.exp);
        end
      end
    end
  end

  task automatic do_load(input logic [127:0] k);
    @(negedge clk);
    key_in = k;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // count negedges from the one after the load edge until ready (R3, R6)
  task automatic time_ready(input int req);
    int cnt = 1;
    check(req, {127'h0, ready}, 128'h0);
    while (!ready && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check(req, 128'(cnt), 128'd11);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    build_sbox();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, all indices zero
    check(1, {127'h0, ready}, 128'h0);
    for (int i = 0; i < 16; i++) push(4'(i), 128'h0, 1);
    drain();

    // R2 R3 R4 R5: published key, forward order
    ref_expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    do_load(128'h2b7e151628aed2a6abf7158809cf4f3c);
    time_ready(3);
    push_all(1'b0, 4);
    push(4'd0, 128'h2b7e151628aed2a6abf7158809cf4f3c, 2);
    push(4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, 5);
    for (int i = 11; i < 16; i++) push(4'(i), 128'h0, 8);  // R8 range
    drain();

    // R7: ready and bank hold with no load
    repeat (25) @(negedge clk);
    check(7, {127'h0, ready}, 128'h1);
    push(4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, 7);
    push(4'd3, exp_rk[3], 7);
    drain();

    // R4: all-zero key, reverse order, known first derived key
    ref_expand(128'h0);
    do_load(128'h0);
    time_ready(6);          // R6 reload while ready
    push_all(1'b1, 8);      // R8 reverse access
    push(4'd1, 128'h62636363626363636263636362636363, 4);
    drain();

    // R6: reload mid-expansion, all-ones key replaced by irregular key
    do_load({128{1'b1}});
    repeat (3) @(negedge clk);
    ref_expand(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    do_load(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    time_ready(6);
    push_all(1'b0, 6);
    drain();

    // R4: all-ones key, mixed order
    ref_expand({128{1'b1}});
    do_load({128{1'b1}});
    time_ready(3);
    for (int k = 0; k < 11; k++) begin
      int r = (k * 7) % 11;
      push(4'(r), exp_rk[r], 4);
    end
    drain();

    finish_run();
  end
endmodule